// File: doc/BRIEF.md
# Charge Slope Termination Detector

This block watches the cell-voltage and thermistor-voltage conversion streams of a battery charger during fast charge and raises a latched request to end the fast-charge phase. Every sampling period, marked by a one-cycle timebase pulse, it averages a burst of conversions on each channel into one sample. The burst length is chosen so that the average cancels mains ripple. Voltage samples feed a drop-from-peak test. Temperature samples feed a slope test that compares each sample with the one taken two periods earlier.

A three-state voltage mode input selects among three behaviours: a sensitive peak-drop test with a 32-conversion burst, a coarser negative-delta test with a 16-conversion burst, or no voltage test at all. A window flag from outside tells the block whether the cell voltage lies in the range where the voltage tests are meaningful. For the first few voltage samples of each fast charge, the negative-delta test is masked so that a voltage spike at turn-on cannot end the charge. Thresholds are parameters in ADC LSBs. The charge state machine reads the request and a 2-bit reason, then clears the request.

Top module: `chg_slope_term`

## Requirements
- R1: After reset, term_req is 0 and term_why is 2'b00.
- R2: A sample_tick while fast_on is high starts a voltage burst. The burst takes 32 vc_valid conversions when mode_sel is 2'b10 (peak mode) and 16 when mode_sel is any other value. The sample is floor(sum/N).
- R3: The same tick starts a temperature burst of 16 tc_valid conversions, and the temperature sample is floor(sum/16).
- R4: With mode_sel 2'b01 (negative-delta mode), a voltage sample that is NDV_DROP (12) LSB or more below the highest earlier voltage sample of this fast charge sets term_req with term_why 2'b01. A drop of 11 does not set it.
- R5: With mode_sel 2'b10, a drop of PVD_DROP (6) LSB or more from the highest earlier sample sets term_req with term_why 2'b10. A drop of 5 does not set it.
- R6: With mode_sel 2'b00 or 2'b11, no voltage drop sets term_req.
- R7: A voltage sample that completes while win_ok is 0 triggers no voltage termination, but it still updates the running peak.
- R8: The first HOLD_SAMP (3) voltage samples after fast charge starts cannot trigger the negative-delta test. The peak test and the slope test are not masked.
- R9: A temperature sample that is SLOPE_DROP (16) LSB or more below the temperature sample two periods earlier sets term_req with term_why 2'b11. The test needs two earlier samples. If the slope test and a voltage test fire on the same sample, the reason is 2'b11.
- R10: term_req and term_why hold until a term_clr pulse. While term_req is set, later criteria do not change term_why.
- R11: A rising edge on fast_on clears term_req, the peak, the temperature history and the hold-off count. Conversions that arrive outside a burst are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_on | input | 1 | Fast charge active; a rising edge starts a new history |
| sample_tick | input | 1 | One-cycle pulse per sampling period; starts both bursts |
| mode_sel | input | 2 | 00 off, 01 negative-delta, 10 peak-drop, 11 off |
| win_ok | input | 1 | Cell voltage lies inside the valid window for voltage tests |
| vc_valid | input | 1 | Cell-voltage conversion strobe |
| vc_code | input | ADC_W | Cell-voltage conversion result |
| tc_valid | input | 1 | Thermistor conversion strobe |
| tc_code | input | ADC_W | Thermistor conversion result |
| term_clr | input | 1 | Clears a latched termination request |
| term_req | output | 1 | Latched request to end fast charge |
| term_why | output | 2 | 01 negative-delta, 10 peak-drop, 11 temperature slope, 00 none |

## Verification
The hardest situation to reach is a sample whose outcome depends on the whole burst. This happens when the verdict changes only if all 32 peak-mode conversions, and not just the first 16, are folded into the average. It also happens when a drop lands exactly at the threshold inside or just after the hold-off window. Directed samples reach these cases by splitting each burst into a first half at one code and a second half at another, so the average falls exactly on or one LSB short of each threshold. A random walk of both channels across random modes then runs against a bench model of the peak, the history and the hold-off count.

// File: rtl/chg_slope_term.sv
module chg_slope_term #(
  parameter int ADC_W      = 12,
  parameter int NDV_DROP   = 12,
  parameter int PVD_DROP   = 6,
  parameter int SLOPE_DROP = 16,
  parameter int HOLD_SAMP  = 3,
  parameter int VN_PVD     = 32,
  parameter int VN_NDV     = 16,
  parameter int TN         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_on,
  input  logic             sample_tick,
  input  logic [1:0]       mode_sel,
  input  logic             win_ok,
  input  logic             vc_valid,
  input  logic [ADC_W-1:0] vc_code,
  input  logic             tc_valid,
  input  logic [ADC_W-1:0] tc_code,
  input  logic             term_clr,
  output logic             term_req,
  output logic [1:0]       term_why
);
  localparam int VSH_P = $clog2(VN_PVD);
  localparam int VSH_N = $clog2(VN_NDV);
  localparam int TSH   = $clog2(TN);
  localparam int SUM_W = ADC_W + VSH_P;
  localparam int CNT_W = VSH_P + 1;
  localparam int HO_W  = $clog2(HOLD_SAMP + 1) + 1;
  localparam logic [1:0] M_NDV = 2'b01;
  localparam logic [1:0] M_PVD = 2'b10;
  localparam logic [1:0] W_SLOPE = 2'b11;

  logic fast_d, fast_rise, burst_go;
  logic v_busy, v_rdy, v_last;
  logic [1:0] v_mode;
  logic [CNT_W-1:0] v_cnt, v_n_m1;
  logic [SUM_W-1:0] v_sum, v_sum_nx;
  logic [ADC_W-1:0] v_avg;
  logic t_busy, t_rdy, t_last;
  logic [CNT_W-1:0] t_cnt;
  logic [SUM_W-1:0] t_sum, t_sum_nx;
  logic [ADC_W-1:0] t_avg;
  logic [ADC_W-1:0] peak, t1, t2, v_fall, t_fall;
  logic p_vld;
  logic [1:0] t_hist;
  logic [HO_W-1:0] ho_cnt;
  logic ndv_hit, pvd_hit, slope_hit;

  assign fast_rise = fast_on & ~fast_d;
  assign burst_go  = sample_tick & fast_on & ~fast_rise;

  // voltage burst averaging
  assign v_n_m1   = (v_mode == M_PVD) ? CNT_W'(VN_PVD - 1) : CNT_W'(VN_NDV - 1);
  assign v_sum_nx = v_sum + {{(SUM_W-ADC_W){1'b0}}, vc_code};
  assign v_last   = v_busy & vc_valid & (v_cnt == v_n_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_busy <= 1'b0; v_rdy <= 1'b0; v_mode <= 2'b00;
      v_cnt <= '0; v_sum <= '0; v_avg <= '0;
    end else if (fast_rise) begin
      v_busy <= 1'b0; v_rdy <= 1'b0; v_cnt <= '0; v_sum <= '0;
    end else if (burst_go) begin
      v_busy <= 1'b1; v_rdy <= 1'b0; v_mode <= mode_sel;
      v_cnt <= '0; v_sum <= '0;
    end else begin
      v_rdy <= v_last;
      if (v_busy && vc_valid) begin
        v_cnt <= v_cnt + 1'b1;
        v_sum <= v_sum_nx;
        if (v_last) begin
          v_busy <= 1'b0;
          v_avg  <= (v_mode == M_PVD) ? ADC_W'(v_sum_nx >> VSH_P)
                                      : ADC_W'(v_sum_nx >> VSH_N);
        end
      end
    end
  end

  // R2
  vcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_busy |-> (v_cnt <= v_n_m1));

  // temperature burst averaging
  assign t_sum_nx = t_sum + {{(SUM_W-ADC_W){1'b0}}, tc_code};
  assign t_last   = t_busy & tc_valid & (t_cnt == CNT_W'(TN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_busy <= 1'b0; t_rdy <= 1'b0; t_cnt <= '0; t_sum <= '0; t_avg <= '0;
    end else if (fast_rise) begin
      t_busy <= 1'b0; t_rdy <= 1'b0; t_cnt <= '0; t_sum <= '0;
    end else if (burst_go) begin
      t_busy <= 1'b1; t_rdy <= 1'b0; t_cnt <= '0; t_sum <= '0;
    end else begin
      t_rdy <= t_last;
      if (t_busy && tc_valid) begin
        t_cnt <= t_cnt + 1'b1;
        t_sum <= t_sum_nx;
        if (t_last) begin
          t_busy <= 1'b0;
          t_avg  <= ADC_W'(t_sum_nx >> TSH);
        end
      end
    end
  end

  // R3
  tcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_busy |-> (t_cnt <= CNT_W'(TN - 1)));

  // termination criteria
  assign v_fall = (peak > v_avg) ? peak - v_avg : '0;
  assign t_fall = (t2 > t_avg) ? t2 - t_avg : '0;

  assign ndv_hit = fast_on & v_rdy & p_vld & win_ok & (v_mode == M_NDV) &
                   (ho_cnt >= HO_W'(HOLD_SAMP)) & (v_fall >= ADC_W'(NDV_DROP));
  assign pvd_hit = fast_on & v_rdy & p_vld & win_ok & (v_mode == M_PVD) &
                   (v_fall >= ADC_W'(PVD_DROP));
  assign slope_hit = fast_on & t_rdy & (t_hist == 2'd2) &
                     (t_fall >= ADC_W'(SLOPE_DROP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak <= '0; p_vld <= 1'b0; ho_cnt <= '0;
      t1 <= '0; t2 <= '0; t_hist <= '0;
    end else if (fast_rise) begin
      peak <= '0; p_vld <= 1'b0; ho_cnt <= '0; t_hist <= '0;
    end else begin
      if (fast_on && v_rdy) begin
        p_vld <= 1'b1;
        if (!p_vld || v_avg > peak) peak <= v_avg;
        if (ho_cnt < HO_W'(HOLD_SAMP)) ho_cnt <= ho_cnt + 1'b1;
      end
      if (fast_on && t_rdy) begin
        t2 <= t1;
        t1 <= t_avg;
        if (t_hist != 2'd2) t_hist <= t_hist + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_req <= 1'b0; term_why <= 2'b00;
    end else if (fast_rise) begin
      term_req <= 1'b0; term_why <= 2'b00;
    end else if (!term_req && (slope_hit || ndv_hit || pvd_hit)) begin
      term_req <= 1'b1;
      term_why <= slope_hit ? W_SLOPE : (ndv_hit ? M_NDV : M_PVD);
    end else if (term_clr) begin
      term_req <= 1'b0; term_why <= 2'b00;
    end
  end

  // R10
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_req && !term_clr && !fast_rise) |=> (term_req && $stable(term_why)));

  // R10
  why_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_req == (term_why != 2'b00));

  // R4
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_req) |-> $past(v_rdy || t_rdy));

  // R8
  ndv_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(term_req) && term_why == M_NDV) |-> $past(ho_cnt >= HO_W'(HOLD_SAMP)));

  // R11
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_rise |=> (!term_req && !p_vld && t_hist == 2'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_d <= 1'b0;
    else        fast_d <= fast_on;
  end
endmodule

// File: tb/chg_slope_term_tb.sv
module chg_slope_term_tb;
  localparam int CLK_P = 10;
  localparam int ADC_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fast_on = 1'b0, sample_tick = 1'b0, win_ok = 1'b1, term_clr = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic vc_valid = 1'b0, tc_valid = 1'b0;
  logic [ADC_W-1:0] vc_code = '0, tc_code = '0;
  logic term_req;
  logic [1:0] term_why;

  int total = 0, bad = 0;
  int m_peak, m_t1, m_t2, m_th, m_ho, m_why;
  bit m_pvld, m_term;
  int vb, tb;

  always #(CLK_P/2) clk = ~clk;

  chg_slope_term u_dut (
    .clk(clk), .rst_n(rst_n), .fast_on(fast_on), .sample_tick(sample_tick),
    .mode_sel(mode_sel), .win_ok(win_ok), .vc_valid(vc_valid), .vc_code(vc_code),
    .tc_valid(tc_valid), .tc_code(tc_code), .term_clr(term_clr),
    .term_req(term_req), .term_why(term_why));

  task automatic check(string req, logic [2:0] got, logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got req/why=%b expected %b", req, got, exp);
    end
  endtask

  function automatic bit v_trig(int mode, bit win, int v);
    if (!m_pvld || !win) return 0;
    if (mode == 1) return (m_ho >= 3) && (m_peak - v >= 12);
    if (mode == 2) return (m_peak - v >= 6);
    return 0;
  endfunction

  function automatic bit t_trig(int t);
    return (m_th == 2) && (m_t2 - t >= 16);
  endfunction

  task automatic start_fast();
    @(negedge clk) fast_on = 1'b0;
    repeat (2) @(negedge clk);
    fast_on = 1'b1;
    repeat (2) @(negedge clk);
    m_pvld = 0; m_ho = 0; m_th = 0; m_term = 0; m_why = 0;
  endtask

  task automatic clear_term();
    @(negedge clk) term_clr = 1'b1;
    @(negedge clk) term_clr = 1'b0;
    m_term = 0; m_why = 0;
    @(negedge clk);
    check("R10 clear", {term_req, term_why}, 3'b000);
  endtask

  // one sampling period; second half of each burst is offset by the tail value
  task automatic sample(string req, int mode, bit win, int vbase, int vtail,
                        int vspr, int tbase, int ttail, int tspr);
    int nv, vsum, tsum, va, ta, c;
    bit vh, th;
    nv = (mode == 2) ? 32 : 16;
    vsum = 0; tsum = 0;
    @(negedge clk) mode_sel = 2'(mode); win_ok = win; sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    for (int i = 0; i < 32; i++) begin
      vc_valid = (i < nv);
      c = vbase + ((i >= nv/2) ? vtail : 0) + int'($urandom_range(vspr, 0));
      vc_code = ADC_W'(c);
      if (i < nv) vsum += c;
      tc_valid = (i < 16);
      c = tbase + ((i >= 8) ? ttail : 0) + int'($urandom_range(tspr, 0));
      tc_code = ADC_W'(c);
      if (i < 16) tsum += c;
      @(negedge clk);
    end
    vc_valid = 1'b0; tc_valid = 1'b0;
    repeat (3) @(negedge clk);
    va = vsum / nv; ta = tsum / 16;
    vh = v_trig(mode, win, va);
    th = t_trig(ta);
    if (!m_term && (vh || th)) begin
      m_term = 1;
      m_why = th ? 3 : mode;
    end
    if (!m_pvld || va > m_peak) m_peak = va;
    m_pvld = 1;
    if (m_ho < 3) m_ho++;
    m_t2 = m_t1; m_t1 = ta;
    if (m_th < 2) m_th++;
    check(req, {term_req, term_why}, {m_term, 2'(m_why)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", {term_req, term_why}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {term_req, term_why}, 3'b000);

    // negative-delta with hold-off and threshold boundary
    start_fast();
    sample("R4 s0", 1, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R4 s1", 1, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R8 ndv masked in holdoff", 1, 1, 980, 0, 0, 2000, 0, 0);
    sample("R4 s3", 1, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R4 drop 11 no term", 1, 1, 989, 0, 0, 2000, 0, 0);
    sample("R4 drop 12 term", 1, 1, 988, 0, 0, 2000, 0, 0);
    sample("R10 latched under slope", 1, 1, 900, 0, 0, 1950, 0, 0);
    clear_term();

    // peak mode: all 32 conversions matter, not masked by hold-off
    start_fast();
    sample("R5 s0", 2, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R2 R8 32-conv avg drop 6", 2, 1, 1000, -12, 0, 2000, 0, 0);
    clear_term();
    start_fast();
    sample("R5 s0", 2, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R5 drop 5 no term", 2, 1, 1000, -10, 0, 2000, 0, 0);

    // voltage tests disabled
    start_fast();
    sample("R6 s0", 0, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R6 mode 00", 0, 1, 900, 0, 0, 2000, 0, 0);
    sample("R6 mode 11", 3, 1, 850, 0, 0, 2000, 0, 0);

    // window flag
    start_fast();
    for (int i = 0; i < 4; i++) sample("R7 ramp", 1, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R7 window low", 1, 0, 900, 0, 0, 2000, 0, 0);
    sample("R7 window back", 1, 1, 900, 0, 0, 2000, 0, 0);
    clear_term();

    // temperature slope
    start_fast();
    sample("R9 t0", 0, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R9 t1", 0, 1, 1000, 0, 0, 1995, 0, 0);
    sample("R9 fall 15 no term", 0, 1, 1000, 0, 0, 1985, 0, 0);
    sample("R9 fall 16 term", 0, 1, 1000, 0, 0, 1979, 0, 0);
    clear_term();
    start_fast();
    sample("R3 t0", 0, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R3 t1", 0, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R3 16-conv avg fall 16", 0, 1, 1000, 0, 0, 2000, -32, 0);
    clear_term();

    // restart clears peak; stray conversions ignored
    start_fast();
    for (int i = 0; i < 4; i++) sample("R11 high", 1, 1, 1000, 0, 0, 2000, 0, 0);
    start_fast();
    for (int i = 0; i < 4; i++) sample("R11 lower", 1, 1, 950, 0, 0, 2000, 0, 0);
    @(negedge clk) vc_valid = 1'b1; vc_code = 12'd10; tc_valid = 1'b1; tc_code = 12'd10;
    repeat (40) @(negedge clk);
    vc_valid = 1'b0; tc_valid = 1'b0;
    @(negedge clk);
    check("R11 stray conversions", {term_req, term_why}, 3'b000);
    sample("R11 small drop after restart", 1, 1, 945, 0, 0, 2000, 0, 0);

    // priority of slope over voltage
    start_fast();
    for (int i = 0; i < 4; i++) sample("R9 prio ramp", 1, 1, 1000, 0, 0, 2000, 0, 0);
    sample("R9 slope wins", 1, 1, 980, 0, 0, 1980, 0, 0);
    clear_term();

    // random walk
    start_fast();
    vb = 1500; tb = 2500;
    for (int n = 0; n < 160; n++) begin
      int md;
      bit w;
      md = int'($urandom_range(3, 0));
      w = ($urandom_range(7, 0) != 0);
      vb = vb + int'($urandom_range(20, 0)) - 11;
      tb = tb + int'($urandom_range(16, 0)) - 9;
      if (vb < 500) vb = 500;
      if (vb > 3000) vb = 3000;
      if (tb < 500) tb = 500;
      if (tb > 3500) tb = 3500;
      sample("R4/R5/R9 random", md, w, vb, int'($urandom_range(8, 0)) - 4, 3,
             tb, int'($urandom_range(8, 0)) - 4, 3);
      if (term_req) clear_term();
      if ($urandom_range(19, 0) == 0) start_fast();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule